// File: doc/BRIEF.md
# Paged Serial Flash Region Eraser

This block clears a region of a page-organised serial flash over a byte-wide transaction port. The region is given as a byte start address and a byte length. Neither has to be a power-of-two multiple, because the page size may be any value (264 or 528 bytes, for example). The block first divides both numbers by the page size and rejects the request if either has a remainder, or if the region runs past the last page of the device. It then walks the region page by page. At each step it uses the eight-page block erase when the current page is the first of an eight-page group and at least eight pages remain. Otherwise it uses the single-page erase.

Each erase is a four-byte command. Its address field is the page number shifted left by a page-offset parameter. After every command the block waits a fixed number of idle cycles, then reads the status byte and repeats the read until the device reports ready. A cap on the number of consecutive not-ready reads turns a device that never finishes into an error. The byte port is shared with the read engine. The serial shifter behind that port, and any retry policy, belong to other blocks.

Top module: `df_erase_seq`

## Requirements
- R1: A start address or a length that is not a whole multiple of PAGE_SIZE is rejected with `err_code` = 1 and `err` pulsed. No byte is sent. This check takes priority over R2.
- R2: If start page plus page count exceeds NUM_PAGES, the request is rejected with `err_code` = 2 and no byte is sent. A region that ends exactly on the last page is accepted.
- R3: A step uses block erase (opcode 0x50) when the current page number has its low three bits zero and at least 8 pages remain. Every other step uses page erase (opcode 0x81).
- R4: An erase command is exactly four bytes. The order is: opcode; bits 23:16 of (page << PAGE_SHIFT); bits 15:8 of the same value; 0x00. `txn_end` is set only on the fourth byte. `txn_byte` and `txn_end` hold steady while `txn_req` waits for `txn_ack`.
- R5: After each erase command the block stays idle for at least POLL_GAP cycles. It then sends a two-byte status read: 0xD7 followed by a dummy 0x00, with `txn_end` set on the second byte. The byte returned with the second acknowledge is ready when bit 7 is 1 and the byte is not 0xFF. Any other value causes another gap and another read.
- R6: A block erase advances the page by 8 and reduces the remaining pages by 8. A page erase changes each by 1. The region is therefore covered with no page erased twice.
- R7: If TIMEOUT_POLLS status reads for one command all report not ready, the run stops with `err_code` = 3 and `err` pulsed. No further erase is sent.
- R8: `busy` is high from the cycle after an accepted `start` until the run ends. A successful run pulses `done` for one cycle, with `err_code` = 0. A failed run pulses `err` instead. A zero length succeeds with no command sent.
- R9: `start` is ignored while `busy` is high.
- R10: During and right after reset, `busy`, `done`, `err` and `txn_req` are 0 and `err_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a region erase (sampled while idle) |
| start_addr | input | ADDR_W | Byte address of first byte of region |
| length | input | ADDR_W | Region length in bytes |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on rejection or timeout |
| err_code | output | 2 | 0 none, 1 alignment, 2 range, 3 timeout; held until next run |
| txn_req | output | 1 | Byte transfer requested |
| txn_byte | output | 8 | Byte to shift out |
| txn_end | output | 1 | Release chip select after this byte |
| txn_ack | input | 1 | Byte transfer complete |
| txn_rx | input | 8 | Byte shifted in during the acknowledged transfer |

## Verification
The bench builds the block with a 24-byte page, a page shift of 5, a 40-page device, a poll gap of 3 cycles and a cap of 4 polls. The page size is not a power of two, so the serial divider and the alignment check face real remainders. The 40-page device puts the exact-end and one-page-over boundaries, and a whole-device erase, within a handful of commands. A shift of 5 makes pages 8 and 32 produce non-zero middle address bytes. The small poll cap makes the timeout path, and the floating-bus 0xFF status, reachable in a few hundred cycles.

// File: rtl/df_erase_pkg.sv
// Shared constants and types for the region eraser.
// Assumes: opcodes are fixed by the flash command set; block is 8 pages.
package df_erase_pkg;
    localparam logic [7:0] OP_BLOCK_ERASE = 8'h50;
    localparam logic [7:0] OP_PAGE_ERASE  = 8'h81;
    localparam logic [7:0] OP_STATUS_RD   = 8'hD7;
    localparam int         BLK_PAGES      = 8;

    typedef enum logic [1:0] {
        ERR_NONE    = 2'd0,
        ERR_ALIGN   = 2'd1,
        ERR_RANGE   = 2'd2,
        ERR_TIMEOUT = 2'd3
    } err_code_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DIV,
        S_CHECK,
        S_CMD,
        S_GAP,
        S_POLL,
        S_ADV
    } seq_state_e;
endpackage

// File: rtl/df_serial_div.sv
// Restoring divider by a constant, one quotient bit per cycle.
// Assumes: 0 < DIVISOR < 2**W; 'go' while running restarts it.
module df_serial_div #(
    parameter int W       = 24,
    parameter int DIVISOR = 264
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    output logic         fin,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem
);
    localparam int CW = $clog2(W + 1);

    logic [W:0]    acc;
    logic [W-1:0]  q;
    logic [CW-1:0] cnt;
    logic          run;
    logic [W:0]    shifted;
    logic          fits;

    // Next partial remainder and whether the divisor fits into it.
    always_comb begin
        shifted = {acc[W-1:0], q[W-1]};
        fits    = shifted >= (W+1)'(DIVISOR);
    end

    // Iterate W steps after 'go', then raise fin.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            q   <= '0;
            cnt <= '0;
            run <= 1'b0;
            fin <= 1'b0;
        end else if (go) begin
            acc <= '0;
            q   <= dividend;
            cnt <= '0;
            run <= 1'b1;
            fin <= 1'b0;
        end else if (run) begin
            acc <= fits ? (shifted - (W+1)'(DIVISOR)) : shifted;
            q   <= {q[W-2:0], fits};
            cnt <= cnt + 1'b1;
            if (cnt == CW'(W - 1)) begin
                run <= 1'b0;
                fin <= 1'b1;
            end
        end
    end

    assign quot = q;
    assign rem  = acc[W-1:0];
endmodule

// File: rtl/df_cmd_form.sv
// Forms the outgoing byte for erase and status-read transactions.
// Assumes: byte_sel counts bytes within the current transaction.
module df_cmd_form
    import df_erase_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int PAGE_SHIFT = 9
) (
    input  logic [ADDR_W-1:0] cur_page,
    input  logic [ADDR_W-1:0] rem_pages,
    input  logic [1:0]        byte_sel,
    input  logic              is_poll,
    output logic              use_block,
    output logic [7:0]        tx_byte,
    output logic              tx_end
);
    logic [7:0] addr_hi;
    logic [7:0] addr_mid;

    // Choose block erase at a group boundary with a full group left.
    assign use_block = (cur_page[2:0] == 3'b000) &&
                       (rem_pages >= ADDR_W'(BLK_PAGES));

    // Device address bytes from the shifted page number.
    assign addr_hi  = 8'((32'(cur_page) << PAGE_SHIFT) >> 16);
    assign addr_mid = 8'((32'(cur_page) << PAGE_SHIFT) >> 8);

    // Select the byte and the end-of-transaction flag.
    always_comb begin
        if (is_poll) begin
            tx_byte = (byte_sel == 2'd0) ? OP_STATUS_RD : 8'h00;
            tx_end  = (byte_sel == 2'd1);
        end else begin
            unique case (byte_sel)
                2'd0:    tx_byte = use_block ? OP_BLOCK_ERASE : OP_PAGE_ERASE;
                2'd1:    tx_byte = addr_hi;
                2'd2:    tx_byte = addr_mid;
                default: tx_byte = 8'h00;
            endcase
            tx_end = (byte_sel == 2'd3);
        end
    end
endmodule

// File: rtl/df_poll_timer.sv
// Spaces status polls and counts consecutive not-ready polls.
// Assumes: POLL_GAP >= 1, TIMEOUT_POLLS >= 1.
module df_poll_timer #(
    parameter int POLL_GAP      = 16,
    parameter int TIMEOUT_POLLS = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic gap_run,
    input  logic miss_clr,
    input  logic miss_inc,
    output logic gap_done,
    output logic last_miss
);
    localparam int GW = $clog2(POLL_GAP + 1);
    localparam int MW = $clog2(TIMEOUT_POLLS + 1);

    logic [GW-1:0] gap_cnt;
    logic [MW-1:0] miss_cnt;

    // Count idle cycles while the gap is running.
    always_ff @(posedge clk) begin
        if (!rst_n || !gap_run) gap_cnt <= '0;
        else                    gap_cnt <= gap_cnt + 1'b1;
    end

    // Count not-ready polls for the current command.
    always_ff @(posedge clk) begin
        if (!rst_n || miss_clr) miss_cnt <= '0;
        else if (miss_inc)      miss_cnt <= miss_cnt + 1'b1;
    end

    assign gap_done  = gap_run && (gap_cnt == GW'(POLL_GAP - 1));
    assign last_miss = (miss_cnt == MW'(TIMEOUT_POLLS - 1));
endmodule

// File: rtl/df_erase_seq.sv
// Region erase sequencer: validates a byte region, then issues page or
// block erases with status polling over a byte transaction port.
// Assumes: the port holds txn_ack for one cycle per byte and returns
// the received byte with it; ADDR_W <= 32.
module df_erase_seq
    import df_erase_pkg::*;
#(
    parameter int ADDR_W        = 24,
    parameter int PAGE_SIZE     = 264,
    parameter int PAGE_SHIFT    = 9,
    parameter int NUM_PAGES     = 2048,
    parameter int POLL_GAP      = 16,
    parameter int TIMEOUT_POLLS = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] length,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [1:0]        err_code,
    output logic              txn_req,
    output logic [7:0]        txn_byte,
    output logic              txn_end,
    input  logic              txn_ack,
    input  logic [7:0]        txn_rx
);
    localparam int NOPS = 2;

    seq_state_e        state;
    logic [1:0]        byte_idx;
    logic [ADDR_W-1:0] cur_page;
    logic [ADDR_W-1:0] rem_pages;
    logic              done_q;
    logic              err_q;
    err_code_e         code_q;

    logic              div_go;
    logic [NOPS-1:0]   div_fin;
    logic [ADDR_W-1:0] div_in   [NOPS];
    logic [ADDR_W-1:0] div_quot [NOPS];
    logic [ADDR_W-1:0] div_rem  [NOPS];

    logic              use_block;
    logic              gap_done;
    logic              last_miss;
    logic              miss_inc;
    logic              dev_ready;
    logic              misaligned;
    logic              over_end;
    logic [ADDR_W:0]   end_page;

    assign div_go    = (state == S_IDLE) && start;
    assign div_in[0] = start_addr;
    assign div_in[1] = length;

    // One divider per operand: start address and length.
    for (genvar g = 0; g < NOPS; g++) begin : g_div
        df_serial_div #(
            .W       (ADDR_W),
            .DIVISOR (PAGE_SIZE)
        ) i_div (
            .clk      (clk),
            .rst_n    (rst_n),
            .go       (div_go),
            .dividend (div_in[g]),
            .fin      (div_fin[g]),
            .quot     (div_quot[g]),
            .rem      (div_rem[g])
        );
    end

    df_cmd_form #(
        .ADDR_W     (ADDR_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) i_form (
        .cur_page  (cur_page),
        .rem_pages (rem_pages),
        .byte_sel  (byte_idx),
        .is_poll   (state == S_POLL),
        .use_block (use_block),
        .tx_byte   (txn_byte),
        .tx_end    (txn_end)
    );

    df_poll_timer #(
        .POLL_GAP      (POLL_GAP),
        .TIMEOUT_POLLS (TIMEOUT_POLLS)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .gap_run   (state == S_GAP),
        .miss_clr  (state == S_CMD),
        .miss_inc  (miss_inc),
        .gap_done  (gap_done),
        .last_miss (last_miss)
    );

    // Region checks on the divider results.
    always_comb begin
        misaligned = (div_rem[0] != '0) || (div_rem[1] != '0);
        end_page   = {1'b0, div_quot[0]} + {1'b0, div_quot[1]};
        over_end   = end_page > (ADDR_W+1)'(NUM_PAGES);
    end

    // Ready means bit 7 set and not a floating all-ones bus.
    assign dev_ready = txn_rx[7] && (txn_rx != 8'hFF);
    assign miss_inc  = (state == S_POLL) && txn_ack && (byte_idx == 2'd1) &&
                       !dev_ready && !last_miss;

    // Main sequencing: validate, erase, gap, poll, advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            byte_idx  <= '0;
            cur_page  <= '0;
            rem_pages <= '0;
            done_q    <= 1'b0;
            err_q     <= 1'b0;
            code_q    <= ERR_NONE;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state)
                S_IDLE: begin
                    if (start) begin
                        state  <= S_DIV;
                        code_q <= ERR_NONE;
                    end
                end
                S_DIV: begin
                    if (&div_fin) state <= S_CHECK;
                end
                S_CHECK: begin
                    cur_page  <= div_quot[0];
                    rem_pages <= div_quot[1];
                    byte_idx  <= '0;
                    if (misaligned) begin
                        state  <= S_IDLE;
                        err_q  <= 1'b1;
                        code_q <= ERR_ALIGN;
                    end else if (over_end) begin
                        state  <= S_IDLE;
                        err_q  <= 1'b1;
                        code_q <= ERR_RANGE;
                    end else if (div_quot[1] == '0) begin
                        state  <= S_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        state <= S_CMD;
                    end
                end
                S_CMD: begin
                    if (txn_ack) begin
                        byte_idx <= byte_idx + 1'b1;
                        if (byte_idx == 2'd3) state <= S_GAP;
                    end
                end
                S_GAP: begin
                    byte_idx <= '0;
                    if (gap_done) state <= S_POLL;
                end
                S_POLL: begin
                    if (txn_ack) begin
                        byte_idx <= byte_idx + 1'b1;
                        if (byte_idx == 2'd1) begin
                            byte_idx <= '0;
                            if (dev_ready) begin
                                state <= S_ADV;
                            end else if (last_miss) begin
                                state  <= S_IDLE;
                                err_q  <= 1'b1;
                                code_q <= ERR_TIMEOUT;
                            end else begin
                                state <= S_GAP;
                            end
                        end
                    end
                end
                S_ADV: begin
                    byte_idx <= '0;
                    if (use_block) begin
                        cur_page  <= cur_page + ADDR_W'(BLK_PAGES);
                        rem_pages <= rem_pages - ADDR_W'(BLK_PAGES);
                    end else begin
                        cur_page  <= cur_page + 1'b1;
                        rem_pages <= rem_pages - 1'b1;
                    end
                    if (rem_pages == (use_block ? ADDR_W'(BLK_PAGES) : ADDR_W'(1))) begin
                        state  <= S_IDLE;
                        done_q <= 1'b1;
                    end else begin
                        state <= S_CMD;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assign busy     = (state != S_IDLE);
    assign done     = done_q;
    assign err      = err_q;
    assign err_code = code_q;
    assign txn_req  = (state == S_CMD) || (state == S_POLL);
endmodule

// File: rtl/df_erase_seq_chk.sv
// Protocol and completion checks on the sequencer ports.
// Assumes: bound to every instance of df_erase_seq.
module df_erase_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       busy,
    input logic       done,
    input logic       err,
    input logic [1:0] err_code,
    input logic       txn_req,
    input logic [7:0] txn_byte,
    input logic       txn_end,
    input logic       txn_ack
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (txn_req && !txn_ack) |=> (txn_req && $stable(txn_byte) && $stable(txn_end))); // R4

    AST_DONE_ERR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R8

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R8

    AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err); // R8

    AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !busy); // R8

    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !txn_req); // R10

    AST_ERR_HAS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != 2'd0)); // R1

    AST_DONE_NO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (err_code == 2'd0)); // R8
endmodule

bind df_erase_seq df_erase_seq_chk i_chk (.*);

// File: tb/test_df_erase_seq.sv
// Bench: table of regions walked by one loop, then directed cases.
module test_df_erase_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AW   = 24;
    localparam int PSZ  = 24;
    localparam int PSH  = 5;
    localparam int NPG  = 40;
    localparam int GAP  = 3;
    localparam int TMO  = 4;

    // Vector table: start, length, busy polls, err, cmds, first op/page, last op/page
    localparam int NV = 12;
    localparam int V_ADDR [NV] = '{0,   24,  192, 168, 25, 0,  840, 768, 0, 0,   936, 25};
    localparam int V_LEN  [NV] = '{192, 192, 408, 216, 24, 30, 144, 192, 0, 960, 24,  2000};
    localparam int V_BP   [NV] = '{0,   1,   2,   0,   0,  0,  0,   1,   0, 0,   2,   0};
    localparam int V_ERR  [NV] = '{0,   0,   0,   0,   1,  1,  2,   0,   0, 0,   0,   1};
    localparam int V_NCMD [NV] = '{1,   8,   3,   2,   0,  0,  0,   1,   0, 5,   1,   0};
    localparam int V_FOP  [NV] = '{'h50,'h81,'h50,'h81,0,  0,  0,   'h50,0, 'h50,'h81,0};
    localparam int V_FPG  [NV] = '{0,   1,   8,   7,   0,  0,  0,   32,  0, 0,   39,  0};
    localparam int V_LOP  [NV] = '{'h50,'h81,'h81,'h50,0,  0,  0,   'h50,0, 'h50,'h81,0};
    localparam int V_LPG  [NV] = '{0,   8,   24,  8,   0,  0,  0,   32,  0, 32,  39,  0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [AW-1:0] length = '0;
    logic          busy, done, err, txn_req, txn_end;
    logic [1:0]    err_code;
    logic [7:0]    txn_byte;
    logic          txn_ack;
    logic [7:0]    txn_rx;

    int n_chk = 0;
    int n_fail = 0;

    // Flash model controls and logs
    logic log_clr = 1'b0;
    int   bp_set = 0;
    logic float_bus = 1'b0;
    int   bidx, busy_left, idle_run, cur_op;
    int   n_cmds, n_polls, min_gap, bad_end, done_cnt, err_cnt;
    int   f_op, f_b1, f_b2, f_b3, l_op, l_b1, l_b2;

    always #(CLK_PERIOD/2) clk = ~clk;

    df_erase_seq #(
        .ADDR_W(AW), .PAGE_SIZE(PSZ), .PAGE_SHIFT(PSH), .NUM_PAGES(NPG),
        .POLL_GAP(GAP), .TIMEOUT_POLLS(TMO)
    ) i_df_erase_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .length(length), .busy(busy), .done(done), .err(err),
        .err_code(err_code), .txn_req(txn_req), .txn_byte(txn_byte),
        .txn_end(txn_end), .txn_ack(txn_ack), .txn_rx(txn_rx)
    );

    function automatic bit is_erase(input int op);
        return (op == 'h50) || (op == 'h81);
    endfunction

    // Flash model: acknowledges each byte one cycle after request, logs traffic.
    always_ff @(posedge clk) begin
        if (!rst_n || log_clr) begin
            txn_ack <= 1'b0; txn_rx <= 8'h00; bidx <= 0; busy_left <= 0;
            idle_run <= 0; cur_op <= 0; n_cmds <= 0; n_polls <= 0;
            min_gap <= 1000; bad_end <= 0; done_cnt <= 0; err_cnt <= 0;
            f_op <= 0; f_b1 <= 0; f_b2 <= 0; f_b3 <= 0;
            l_op <= 0; l_b1 <= 0; l_b2 <= 0;
        end else begin
            if (done) done_cnt <= done_cnt + 1;
            if (err)  err_cnt  <= err_cnt + 1;
            idle_run <= txn_req ? 0 : idle_run + 1;
            if (txn_req && !txn_ack) begin
                txn_ack <= 1'b1;
                txn_rx  <= 8'h00;
                if (bidx == 0) begin
                    cur_op <= int'(txn_byte);
                    if (txn_end) bad_end <= bad_end + 1;
                    if (is_erase(int'(txn_byte))) begin
                        n_cmds <= n_cmds + 1;
                        if (n_cmds == 0) f_op <= int'(txn_byte);
                        l_op <= int'(txn_byte);
                    end
                    if (txn_byte == 8'hD7) begin
                        n_polls <= n_polls + 1;
                        if (idle_run < min_gap) min_gap <= idle_run;
                    end
                end else if (is_erase(cur_op)) begin
                    if (txn_end != (bidx == 3)) bad_end <= bad_end + 1;
                    if (bidx == 1) begin l_b1 <= int'(txn_byte); if (n_cmds == 1) f_b1 <= int'(txn_byte); end
                    if (bidx == 2) begin l_b2 <= int'(txn_byte); if (n_cmds == 1) f_b2 <= int'(txn_byte); end
                    if (bidx == 3 && n_cmds == 1) f_b3 <= int'(txn_byte);
                    if (txn_end) busy_left <= bp_set;
                end else if (cur_op == 'hD7) begin
                    if (!txn_end) bad_end <= bad_end + 1;
                    if (float_bus)           txn_rx <= 8'hFF;
                    else if (busy_left == 0) txn_rx <= 8'h81;
                    else begin
                        txn_rx    <= 8'h7F;
                        busy_left <= busy_left - 1;
                    end
                end
                bidx <= txn_end ? 0 : bidx + 1;
            end else begin
                txn_ack <= 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_case(input int a, input int l, input int bp, output int busy_seen);
        @(negedge clk);
        log_clr = 1'b1; bp_set = bp;
        @(negedge clk);
        log_clr = 1'b0;
        start_addr = AW'(a); length = AW'(l); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_seen = int'(busy);
        for (int k = 0; k < 20000 && done_cnt == 0 && err_cnt == 0; k++) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    // Global watchdog: counted as a failure, then summary.
    initial begin
        repeat (190000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int bs;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!busy && !done && !err && !txn_req && err_code == 2'd0, "R10 reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !txn_req, "R10 after reset", int'(txn_req), 0);

        // Table walk: R1 R2 R3 R4 R5 R6 R8
        for (int v = 0; v < NV; v++) begin
            run_case(V_ADDR[v], V_LEN[v], V_BP[v], bs);
            chk(bs == 1, "R8 busy after start", bs, 1);
            chk(!busy, "R8 idle at end", int'(busy), 0);
            chk(int'(err_code) == V_ERR[v], "R1 R2 error code", int'(err_code), V_ERR[v]);
            chk(done_cnt == (V_ERR[v] == 0 ? 1 : 0), "R8 done pulses", done_cnt, V_ERR[v] == 0 ? 1 : 0);
            chk(err_cnt == (V_ERR[v] != 0 ? 1 : 0), "R8 err pulses", err_cnt, V_ERR[v] != 0 ? 1 : 0);
            chk(n_cmds == V_NCMD[v], "R6 command count", n_cmds, V_NCMD[v]);
            chk(n_polls == V_NCMD[v] * (V_BP[v] + 1), "R5 poll count", n_polls, V_NCMD[v] * (V_BP[v] + 1));
            chk(bad_end == 0, "R4 end flag position", bad_end, 0);
            if (V_NCMD[v] > 0) begin
                chk(f_op == V_FOP[v], "R3 first opcode", f_op, V_FOP[v]);
                chk(l_op == V_LOP[v], "R3 last opcode", l_op, V_LOP[v]);
                chk(f_b1 == (((V_FPG[v] << PSH) >> 16) & 255), "R4 first addr hi", f_b1, ((V_FPG[v] << PSH) >> 16) & 255);
                chk(f_b2 == (((V_FPG[v] << PSH) >> 8) & 255), "R4 first addr mid", f_b2, ((V_FPG[v] << PSH) >> 8) & 255);
                chk(f_b3 == 0, "R4 first zero byte", f_b3, 0);
                chk(l_b2 == (((V_LPG[v] << PSH) >> 8) & 255), "R6 last addr mid", l_b2, ((V_LPG[v] << PSH) >> 8) & 255);
                chk(l_b1 == (((V_LPG[v] << PSH) >> 16) & 255), "R6 last addr hi", l_b1, ((V_LPG[v] << PSH) >> 16) & 255);
                chk(min_gap >= GAP, "R5 poll spacing", min_gap, GAP);
            end
        end

        // R7: device never ready
        run_case(0, 24, 1000, bs);
        chk(int'(err_code) == 3 && err_cnt == 1, "R7 timeout code", int'(err_code), 3);
        chk(n_polls == TMO, "R7 poll cap", n_polls, TMO);
        chk(n_cmds == 1, "R7 no further erase", n_cmds, 1);

        // R5: all-ones status is never taken as ready
        float_bus = 1'b1;
        run_case(0, 48, 0, bs);
        float_bus = 1'b0;
        chk(int'(err_code) == 3, "R5 floating status", int'(err_code), 3);
        chk(n_cmds == 1, "R5 floating one command", n_cmds, 1);

        // R9: start while busy is ignored
        @(negedge clk);
        log_clr = 1'b1; bp_set = 3;
        @(negedge clk);
        log_clr = 1'b0; start_addr = AW'(0); length = AW'(192); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (40) @(negedge clk);
        start_addr = AW'(24); length = AW'(48); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int k = 0; k < 20000 && done_cnt == 0 && err_cnt == 0; k++) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(n_cmds == 1 && f_op == 'h50, "R9 second start ignored", n_cmds, 1);
        chk(done_cnt == 1 && !busy, "R9 single completion", done_cnt, 1);

        // R10: reset in mid-run returns to idle
        @(negedge clk);
        start_addr = AW'(0); length = AW'(960); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (60) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!busy && !txn_req && !done && !err && err_code == 2'd0, "R10 mid-run reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule